// File: doc/BRIEF.md
# Bank-Split In-Order DRAM Command Scheduler

This block sits in a memory controller between the request network and the DRAM command bus. Every incoming read or write is steered by its bank number into a queue that belongs to that bank alone. Each queue is strictly first-in first-out, so only the oldest request of a bank is ever considered. No associative search across queue entries takes place. Because every bank has its own queue, the heads of different banks progress independently, and bank-level parallelism is kept.

For each bank head the block derives the next DRAM command. A closed bank needs an activate followed by a column access. A head that hits the open row needs only the column access. A head that conflicts with the open row needs a precharge, then an activate, then the column access. Per-bank down-counters enforce the activate-to-column, activate-to-precharge, precharge-to-activate and activate-to-activate spacing, and a shared counter spaces activates across banks. At most one command leaves per cycle. When several banks can issue, a rotating pointer picks among them. A column command retires the head request.

Top module: `bank_sched`

## Requirements
- R1: Requests enter the queue of the bank they name. Column commands of a bank serve that bank's requests oldest first, carrying the request's row and column. The command code on cmd_op is 0 for precharge, 1 for activate, 2 for read and 3 for write.
- R2: A head request to a bank with no open row produces an activate of the head row. In an idle block, that activate appears on the bus two cycles after the request is accepted.
- R3: A head request to the open row produces only a read or write command, with no precharge or activate. In an idle block, it appears two cycles after acceptance.
- R4: A head request to a row other than the open one produces a precharge, then an activate of the new row, then the column command.
- R5: A column command follows the activate of its bank by at least T_RCD cycles, and by exactly T_RCD cycles when nothing else delays it.
- R6: A precharge follows the activate of its bank by at least T_RAS cycles, and by exactly T_RAS cycles when it is waiting only on that limit.
- R7: An activate follows the last precharge of its bank by at least T_RP cycles and the last activate of its bank by at least T_RC cycles. When unconstrained otherwise, it comes at the later of the two limits.
- R8: Activates to any two banks are at least T_RRD cycles apart, and exactly T_RRD cycles apart when the second one waits only on this limit.
- R9: req_ready is low exactly when the bank named on req_bank holds DEPTH requests. A full bank does not lower req_ready for other banks.
- R10: After reset no command is issued, req_ready is high and every bank is closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Queue of req_bank can accept |
| req_bank | input | $clog2(NBANK) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 for write, 0 for read |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_op | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| cmd_bank | output | $clog2(NBANK) | Bank of the command |
| cmd_row | output | ROW_W | Row of the command's head request |
| cmd_col | output | COL_W | Column of the command's head request |

## Verification
A wrong open-row record shows up on the very next command to that bank. It appears either as a missing or extra precharge/activate before a column access, or as a column access carrying a row that was never activated. A timing counter loaded or decremented wrongly shows as a gap between two commands of a bank that is shorter than the limit, or longer than it in the directed idle cases, within one row cycle. A queue pointer error surfaces as a column command whose column or direction differs from the oldest pending request of that bank, or as req_ready disagreeing with the count of requests taken and retired.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
   typedef enum logic [1:0] {
      OP_PRE = 2'd0,
      OP_ACT = 2'd1,
      OP_RD  = 2'd2,
      OP_WR  = 2'd3
   } dram_op_e;
endpackage

// File: rtl/bsched_fifo.sv
module bsched_fifo #(
   parameter int W     = 21,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + AW'(1);
         if (pop)  rp <= rp + AW'(1);
         case ({push, pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   assign dout  = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/bsched_bank.sv
module bsched_bank
   import bsched_pkg::*;
#(
   parameter int ROW_W = 12,
   parameter int CNT_W = 6,
   parameter int T_RP  = 13,
   parameter int T_RCD = 12,
   parameter int T_RAS = 21,
   parameter int T_RC  = 34
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             head_valid,
   input  logic [ROW_W-1:0] head_row,
   input  logic             rrd_ok,
   input  logic             issue,
   output dram_op_e         need_op,
   output logic             can_issue
);
   logic             open_q;
   logic [ROW_W-1:0] open_row;
   logic [CNT_W-1:0] rp_c, rcd_c, ras_c, rc_c;

   function automatic logic [CNT_W-1:0] dn(input logic [CNT_W-1:0] v);
      return (v == '0) ? v : v - CNT_W'(1);
   endfunction

   always_comb begin
      if (!open_q)                 need_op = OP_ACT;
      else if (open_row == head_row) need_op = OP_RD;
      else                         need_op = OP_PRE;
   end

   always_comb begin
      case (need_op)
         OP_ACT:  can_issue = head_valid && rp_c == '0 && rc_c == '0 && rrd_ok;
         OP_PRE:  can_issue = head_valid && ras_c == '0;
         default: can_issue = head_valid && rcd_c == '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         open_row <= '0;
         rp_c     <= '0;
         rcd_c    <= '0;
         ras_c    <= '0;
         rc_c     <= '0;
      end else begin
         rp_c  <= dn(rp_c);
         rcd_c <= dn(rcd_c);
         ras_c <= dn(ras_c);
         rc_c  <= dn(rc_c);
         if (issue && need_op == OP_ACT) begin
            open_q   <= 1'b1;
            open_row <= head_row;
            rcd_c    <= CNT_W'(T_RCD - 1);
            ras_c    <= CNT_W'(T_RAS - 1);
            rc_c     <= CNT_W'(T_RC - 1);
         end else if (issue && need_op == OP_PRE) begin
            open_q <= 1'b0;
            rp_c   <= CNT_W'(T_RP - 1);
         end
      end
   end
endmodule

// File: rtl/bsched_rr.sv
module bsched_rr #(
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   output logic                 gnt_valid,
   output logic [$clog2(N)-1:0] gnt_idx
);
   localparam int IW = $clog2(N);

   logic [IW-1:0] ptr;

   always_comb begin
      logic [IW-1:0] idx;
      gnt_valid = 1'b0;
      gnt_idx   = ptr;
      for (int i = 0; i < N; i++) begin
         idx = ptr + IW'(i);
         if (!gnt_valid && req[idx]) begin
            gnt_valid = 1'b1;
            gnt_idx   = idx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptr <= '0;
      else if (gnt_valid) ptr <= gnt_idx + IW'(1);
   end
endmodule

// File: rtl/bank_sched.sv
module bank_sched
   import bsched_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int ROW_W = 12,
   parameter int COL_W = 8,
   parameter int DEPTH = 8,
   parameter int T_RP  = 13,
   parameter int T_RCD = 12,
   parameter int T_RAS = 21,
   parameter int T_RC  = 34,
   parameter int T_RRD = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [$clog2(NBANK)-1:0] req_bank,
   input  logic [ROW_W-1:0]         req_row,
   input  logic [COL_W-1:0]         req_col,
   input  logic                     req_write,
   output logic                     cmd_valid,
   output logic [1:0]               cmd_op,
   output logic [$clog2(NBANK)-1:0] cmd_bank,
   output logic [ROW_W-1:0]         cmd_row,
   output logic [COL_W-1:0]         cmd_col
);
   localparam int BANK_W = $clog2(NBANK);
   localparam int ENT_W  = ROW_W + COL_W + 1;
   localparam int T_M1   = (T_RP > T_RCD) ? T_RP : T_RCD;
   localparam int T_M2   = (T_RAS > T_RC) ? T_RAS : T_RC;
   localparam int T_M3   = (T_M1 > T_M2) ? T_M1 : T_M2;
   localparam int T_MAX  = (T_M3 > T_RRD) ? T_M3 : T_RRD;
   localparam int CNT_W  = $clog2(T_MAX + 1);

   if (DEPTH != 8 && DEPTH != 16 && DEPTH != 32 && DEPTH != 64) begin : g_bad_depth
      $error("bank_sched: DEPTH must be 8, 16, 32 or 64");
   end
   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("bank_sched: NBANK must be a power of two of at least 2");
   end
   if (T_RP < 1 || T_RCD < 1 || T_RAS < 1 || T_RC < 1 || T_RRD < 1) begin : g_bad_timing
      $error("bank_sched: every timing value must be at least 1");
   end

   logic [NBANK-1:0] q_full, q_empty, bank_go;
   logic [ENT_W-1:0] head [NBANK];
   dram_op_e         need [NBANK];
   logic             gnt_valid;
   logic [BANK_W-1:0] gnt_idx;
   logic [CNT_W-1:0] rrd_c;

   assign req_ready = !q_full[req_bank];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic push_b, issue_b, pop_b;
      assign push_b  = req_valid && req_ready && (req_bank == BANK_W'(b));
      assign issue_b = gnt_valid && (gnt_idx == BANK_W'(b));
      assign pop_b   = issue_b && (need[b] == OP_RD);

      bsched_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_q (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (push_b),
         .din   ({req_write, req_row, req_col}),
         .pop   (pop_b),
         .dout  (head[b]),
         .empty (q_empty[b]),
         .full  (q_full[b])
      );

      bsched_bank #(
         .ROW_W(ROW_W), .CNT_W(CNT_W),
         .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .head_valid (!q_empty[b]),
         .head_row   (head[b][COL_W +: ROW_W]),
         .rrd_ok     (rrd_c == '0),
         .issue      (issue_b),
         .need_op    (need[b]),
         .can_issue  (bank_go[b])
      );
   end

   bsched_rr #(.N(NBANK)) u_rr (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (bank_go),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx)
   );

   dram_op_e         sel_op;
   logic [ENT_W-1:0] sel_ent;
   assign sel_op  = need[gnt_idx];
   assign sel_ent = head[gnt_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rrd_c     <= '0;
         cmd_valid <= 1'b0;
         cmd_op    <= 2'd0;
         cmd_bank  <= '0;
         cmd_row   <= '0;
         cmd_col   <= '0;
      end else begin
         if (gnt_valid && sel_op == OP_ACT) rrd_c <= CNT_W'(T_RRD - 1);
         else if (rrd_c != '0)              rrd_c <= rrd_c - CNT_W'(1);
         cmd_valid <= gnt_valid;
         cmd_op    <= (sel_op == OP_RD && sel_ent[ENT_W-1]) ? OP_WR : sel_op;
         cmd_bank  <= gnt_idx;
         cmd_row   <= sel_ent[COL_W +: ROW_W];
         cmd_col   <= sel_ent[COL_W-1:0];
      end
   end
endmodule

// File: rtl/bank_sched_chk.sv
module bank_sched_chk #(
   parameter int NBANK = 4,
   parameter int ROW_W = 12,
   parameter int DEPTH = 8,
   parameter int T_RP  = 13,
   parameter int T_RCD = 12,
   parameter int T_RAS = 21,
   parameter int T_RC  = 34,
   parameter int T_RRD = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_ready,
   input logic [$clog2(NBANK)-1:0] req_bank,
   input logic                     cmd_valid,
   input logic [1:0]               cmd_op,
   input logic [$clog2(NBANK)-1:0] cmd_bank,
   input logic [ROW_W-1:0]         cmd_row
);
   localparam int SAT = T_RP + T_RCD + T_RAS + T_RC + T_RRD;
   localparam int SW  = $clog2(SAT + 1);
   localparam int OW  = $clog2(DEPTH + 1);

   logic [OW-1:0]    occ [NBANK];
   logic             opn [NBANK];
   logic [ROW_W-1:0] orow [NBANK];
   logic [SW-1:0]    s_act [NBANK];
   logic [SW-1:0]    s_pre [NBANK];
   logic [SW-1:0]    s_any;
   logic             is_pre, is_act, is_col;
   logic [OW-1:0]    occ_req;

   assign is_pre = cmd_valid && cmd_op == 2'd0;
   assign is_act = cmd_valid && cmd_op == 2'd1;
   assign is_col = cmd_valid && cmd_op[1];

   always_comb occ_req = occ[req_bank] - ((is_col && cmd_bank == req_bank) ? OW'(1) : OW'(0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_any <= SW'(SAT);
         for (int b = 0; b < NBANK; b++) begin
            occ[b]   <= '0;
            opn[b]   <= 1'b0;
            orow[b]  <= '0;
            s_act[b] <= SW'(SAT);
            s_pre[b] <= SW'(SAT);
         end
      end else begin
         if (is_act)                s_any <= SW'(1);
         else if (s_any != SW'(SAT)) s_any <= s_any + SW'(1);
         for (int b = 0; b < NBANK; b++) begin
            case ({req_valid && req_ready && req_bank == b, is_col && cmd_bank == b})
               2'b10:   occ[b] <= occ[b] + OW'(1);
               2'b01:   occ[b] <= occ[b] - OW'(1);
               default: occ[b] <= occ[b];
            endcase
            if (is_act && cmd_bank == b) begin
               opn[b]   <= 1'b1;
               orow[b]  <= cmd_row;
               s_act[b] <= SW'(1);
            end else if (s_act[b] != SW'(SAT)) s_act[b] <= s_act[b] + SW'(1);
            if (is_pre && cmd_bank == b) begin
               opn[b]   <= 1'b0;
               s_pre[b] <= SW'(1);
            end else if (s_pre[b] != SW'(SAT)) s_pre[b] <= s_pre[b] + SW'(1);
         end
      end
   end

   assert_col_has_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> occ[cmd_bank] != '0);
   assert_act_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> !opn[cmd_bank]);
   assert_col_open_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> (opn[cmd_bank] && orow[cmd_bank] == cmd_row));
   assert_pre_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> opn[cmd_bank]);
   assert_rcd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> s_act[cmd_bank] >= SW'(T_RCD));
   assert_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> s_act[cmd_bank] >= SW'(T_RAS));
   assert_rp_rc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> (s_pre[cmd_bank] >= SW'(T_RP) && s_act[cmd_bank] >= SW'(T_RC)));
   assert_rrd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> s_any >= SW'(T_RRD));
   assert_ready_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready == (occ_req != OW'(DEPTH)));
endmodule

bind bank_sched bank_sched_chk #(
   .NBANK(NBANK), .ROW_W(ROW_W), .DEPTH(DEPTH),
   .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RRD(T_RRD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_bank  (req_bank),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_bank  (cmd_bank),
   .cmd_row   (cmd_row)
);

// File: tb/sim_bank_sched.sv
`timescale 1ns/1ps
module sim_bank_sched;
   localparam int NB = 4, ROW_W = 12, COL_W = 8, DEPTH = 8;
   localparam int T_RP = 13, T_RCD = 12, T_RAS = 21, T_RC = 34, T_RRD = 8;
   localparam int QN = 256;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready, req_write = 1'b0;
   logic [1:0] req_bank = '0;
   logic [ROW_W-1:0] req_row = '0;
   logic [COL_W-1:0] req_col = '0;
   logic cmd_valid;
   logic [1:0] cmd_op, cmd_bank;
   logic [ROW_W-1:0] cmd_row;
   logic [COL_W-1:0] cmd_col;

   always #5 clk = ~clk;

   bank_sched u0 (.*);

   int total = 0, bad = 0, cyc = 0, acc_cyc = 0, n_rowcmd = 0, last_act_any = -1000;
   bit acc_flag = 0, saw_full0 = 0;
   int q_row [NB][QN], q_col [NB][QN], q_wr [NB][QN];
   int q_h [NB], q_t [NB];
   bit opn [NB];
   int orow [NB], last_act [NB], prev_act [NB], last_pre [NB], last_col [NB];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      for (int b = 0; b < NB; b++) begin
         q_h[b] = 0; q_t[b] = 0; opn[b] = 0; orow[b] = 0;
         last_act[b] = -1000; prev_act[b] = -1000; last_pre[b] = -1000; last_col[b] = -1000;
      end
   end

   // monitor and reference model, evaluated away from the active edge
   always @(negedge clk) begin
      int b, hr;
      bit has;
      cyc = cyc + 1;
      if (rst_n) begin
         if (cmd_valid) begin
            b   = int'(cmd_bank);
            has = (q_t[b] != q_h[b]);
            hr  = has ? q_row[b][q_h[b] % QN] : -1;
            case (cmd_op)
               2'd1: begin
                  n_rowcmd++;
                  chk(!opn[b], "R2 activate to closed bank", opn[b], 0);
                  chk(has && int'(cmd_row) == hr, "R1 activate row is head row", int'(cmd_row), hr);
                  chk(cyc - last_act_any >= T_RRD, "R8 activate spacing", cyc - last_act_any, T_RRD);
                  chk(cyc - last_act[b] >= T_RC, "R7 same-bank activate spacing", cyc - last_act[b], T_RC);
                  chk(cyc - last_pre[b] >= T_RP, "R7 precharge to activate", cyc - last_pre[b], T_RP);
                  opn[b] = 1; orow[b] = int'(cmd_row);
                  prev_act[b] = last_act[b]; last_act[b] = cyc; last_act_any = cyc;
               end
               2'd0: begin
                  n_rowcmd++;
                  chk(opn[b], "R4 precharge of open bank", opn[b], 1);
                  chk(has && hr != orow[b], "R4 precharge only on conflict", hr, orow[b]);
                  chk(cyc - last_act[b] >= T_RAS, "R6 activate to precharge", cyc - last_act[b], T_RAS);
                  opn[b] = 0; last_pre[b] = cyc;
               end
               default: begin
                  chk(has && opn[b] && orow[b] == hr, "R3 column on open row", orow[b], hr);
                  if (has) begin
                     chk(int'(cmd_col) == q_col[b][q_h[b] % QN], "R1 column in order",
                         int'(cmd_col), q_col[b][q_h[b] % QN]);
                     chk(int'(cmd_op == 2'd3) == q_wr[b][q_h[b] % QN], "R1 read/write code",
                         int'(cmd_op), 2 + q_wr[b][q_h[b] % QN]);
                     q_h[b]++;
                  end
                  chk(cyc - last_act[b] >= T_RCD, "R5 activate to column", cyc - last_act[b], T_RCD);
                  last_col[b] = cyc;
               end
            endcase
         end
         b = int'(req_bank);
         chk(req_ready == ((q_t[b] - q_h[b]) != DEPTH), "R9 ready versus occupancy",
             req_ready, (q_t[b] - q_h[b]) != DEPTH);
         if (req_valid && !req_ready && req_bank == 2'd0) saw_full0 = 1;
         acc_flag = req_valid && req_ready;
         if (acc_flag) begin
            q_row[b][q_t[b] % QN] = int'(req_row);
            q_col[b][q_t[b] % QN] = int'(req_col);
            q_wr[b][q_t[b] % QN]  = int'(req_write);
            q_t[b]++;
            acc_cyc = cyc;
         end
      end
      if (cyc >= 150000) begin
         chk(0, "watchdog expired", cyc, 0);
         summary();
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic send(input int bank, input int row, input int col, input int wr);
      req_valid = 1'b1; req_bank = 2'(bank); req_row = ROW_W'(row);
      req_col = COL_W'(col); req_write = wr[0];
      do begin @(posedge clk); #1; end while (!acc_flag);
      req_valid = 1'b0;
   endtask

   function automatic bit all_empty();
      for (int b = 0; b < NB; b++) if (q_t[b] != q_h[b]) return 0;
      return 1;
   endfunction

   task automatic drain(input int extra);
      int guard = 0;
      while (!all_empty() && guard < 20000) begin tick(1); guard++; end
      chk(all_empty(), "R1 every request served", guard, 0);
      tick(extra);
   endtask

   initial begin
      int c, c1, n0, gap;
      void'($urandom(32'd20240611));
      tick(4);
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R10 no command in reset", cmd_valid, 0);
      chk(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
      @(posedge clk); #1 rst_n = 1'b1;
      tick(3);
      @(negedge clk);
      chk(cmd_valid == 1'b0 && n_rowcmd == 0, "R10 idle after reset", cmd_valid, 0);
      chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
      @(posedge clk); #1;

      // closed bank: activate then column
      send(0, 5, 3, 0); c = acc_cyc; tick(25);
      chk(last_act[0] == c + 2, "R2 activate latency", last_act[0], c + 2);
      chk(last_col[0] == last_act[0] + T_RCD, "R5 exact tRCD", last_col[0] - last_act[0], T_RCD);

      // open-row hit: write only
      n0 = n_rowcmd;
      send(0, 5, 7, 1); c = acc_cyc; tick(10);
      chk(last_col[0] == c + 2, "R3 hit latency", last_col[0], c + 2);
      chk(n_rowcmd == n0, "R3 no row command on hit", n_rowcmd, n0);
      tick(60);

      // row conflict: precharge, activate, column
      send(0, 9, 1, 0); c = acc_cyc; tick(60);
      chk(last_pre[0] == c + 2, "R4 precharge latency", last_pre[0], c + 2);
      chk(last_act[0] == last_pre[0] + T_RP, "R7 exact tRP", last_act[0] - last_pre[0], T_RP);
      chk(last_col[0] == last_act[0] + T_RCD, "R4 column after reopen", last_col[0] - last_act[0], T_RCD);

      // back-to-back conflict on a fresh bank: tRAS then tRP/tRC
      send(1, 1, 0, 0); c1 = acc_cyc; send(1, 2, 0, 0); tick(90);
      gap = (T_RAS + T_RP > T_RC) ? T_RAS + T_RP : T_RC;
      chk(prev_act[1] == c1 + 2, "R2 first activate bank 1", prev_act[1], c1 + 2);
      chk(last_pre[1] == prev_act[1] + T_RAS, "R6 exact tRAS", last_pre[1] - prev_act[1], T_RAS);
      chk(last_act[1] == prev_act[1] + gap, "R7 reactivate spacing", last_act[1] - prev_act[1], gap);

      // two banks activating in adjacent cycles
      send(2, 4, 0, 0); c = acc_cyc; send(3, 4, 0, 0); tick(40);
      chk(last_act[2] == c + 2, "R8 first activate", last_act[2], c + 2);
      chk(last_act[3] == last_act[2] + T_RRD, "R8 exact tRRD", last_act[3] - last_act[2], T_RRD);
      drain(60);

      // fill bank 0 with conflicting rows
      for (int i = 0; i < DEPTH + 2; i++) send(0, 20 + (i % 2), i, i % 2);
      chk(saw_full0, "R9 full bank stalls", saw_full0, 1);
      req_bank = 2'd0;
      @(negedge clk);
      chk(req_ready == 1'b0, "R9 full bank not ready", req_ready, 0);
      @(posedge clk); #1 req_bank = 2'd1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R9 other bank still ready", req_ready, 1);
      @(posedge clk); #1;
      drain(40);

      // constrained random traffic, checked by the monitor
      for (int i = 0; i < 1500; i++) begin
         send(int'($urandom % NB), int'($urandom % 3), int'($urandom % 256), int'($urandom % 2));
         if ($urandom % 4 == 0) tick(1 + int'($urandom % 5));
      end
      drain(10);

      summary();
      $finish;
   end
endmodule